// File: doc/BRIEF.md
# DDR SDRAM Command Protocol Checker

This block sits beside the command bus of a four-bank double-data-rate SDRAM and samples the bus at every rising clock edge. It decodes each cycle into one command from the clock-enable, chip-select, row/column strobes, write enable, bank address and the A10 auto-precharge line. It keeps a model of every bank: whether a row is open, plus countdown timers for each minimum spacing. When a command breaks a bank-state rule or arrives too early, the block raises a one-cycle violation flag together with a 4-bit error code. The decoded command and its target bank are reported in every cycle, so a test environment can log the bus as well as its errors.

All spacing limits are parameters counted in clock cycles. The defaults match a 7.5 ns clock. The offending command is still applied to the bank model, so checking carries on without a reset after the first error. The burst length used for auto-precharge tracking is taken from the last mode-register write.

Top module: `dram_cmd_monitor`

## Requirements
- R1: With the previous-cycle clock enable high and chip select low, {RAS#,CAS#,WE#} decodes to a command, reported on cmd_o: 000 gives mode set (1), or extended mode set (2) when BA0 is 1; 001 gives refresh (3) with CKE high, or self-refresh entry (4) with CKE low; 011 gives activate (5); 101 gives read (6); 100 gives write (7); 110 gives burst stop (8); 010 gives precharge (9); 111 gives no-op (0). bank_o carries BA for activate, read, write and precharge, and is 0 otherwise.
- R2: A cycle with chip select high, or with the clock enable low in the previous cycle, decodes as no-op (0) with bank 0 and never raises a violation. This holds whatever the strobe lines carry.
- R3: A mode set, extended mode set, refresh or self-refresh entry while any bank is open gives error 1.
- R4: Any command other than a no-op fewer than T_MRD (default 2) cycles after a mode set or extended mode set gives error 2.
- R5: Any command other than a no-op fewer than T_RFC (default 10) cycles after a refresh gives error 3.
- R6: A read or write to a closed bank gives error 4. An activate to an open bank gives error 8.
- R7: A read or write fewer than T_RCD (default 3) cycles after the activate of its bank gives error 6.
- R8: An activate gives error 9 when it comes fewer than T_RP (default 3) cycles after its bank closed. It gives error 10 when it comes fewer than T_RC (default 9) cycles after the last activate of the same bank. It gives error 11 when it comes fewer than T_RRD (default 2) cycles after any activate.
- R9: A precharge of an open bank fewer than T_RAS (default 6) cycles after that bank's activate gives error 12.
- R10: A precharge with A10 high ignores BA, applies the rule of R9 to every open bank, and closes all four banks.
- R11: A read or write with A10 high to bank b starts an auto-precharge burst that lasts BL/2 cycles after the command. During the burst, a read or write to b gives error 5, and a read or write to another bank gives error 7. The bank closes when the burst ends, and the T_RP window of R8 is counted from the last burst cycle.
- R12: The burst length is latched from A2:A0 of a mode set with BA0 0: 001 gives 2, 010 gives 4, 011 gives 8, and any other code keeps the previous value. The extended mode set never changes it. The value after reset is 8.
- R13: All outputs are registered and appear one cycle after the sampling edge. viol_o is high only in that cycle, and the offending command still updates the bank model.
- R14: When several rules fail, the code reported is the first in this order: 1, 2, 3, then by command 4, 5, 6, 7 for read and write, 8, 9, 10, 11 for activate, and 12 for precharge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command bus clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke_i | input | 1 | Clock enable |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | BANK_BITS | Bank address |
| a10_i | input | 1 | All-bank / auto-precharge select |
| amode_i | input | 3 | A2:A0, burst-length code for mode set |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | BANK_BITS | Target bank of the decoded command |
| viol_o | output | 1 | One-cycle violation pulse |
| err_o | output | 4 | Error code, 0 when there is no violation |

## Verification
Every result of this block is due in the single cycle after the rising edge that sampled the command: one register stage holds the decoded command, the bank and the error code. Each window in the requirements is counted from the edge of one command to the edge of the next. The driver changes the bus on the falling edge and pushes one expected item per cycle into a queue, so a command issued k cycles after another lands exactly k queue entries later. The monitor pops one item 1 ns after each rising edge and compares all four outputs. Because the bus changes only on falling edges, no comparison depends on the order of processes at the edge.

// File: rtl/ddr_chk_pkg.sv
// Package ddr_chk_pkg
// Shared command and error encodings for the DRAM command checker.
// Assumes at most burst length 8, so half a burst fits in 3 bits.
package ddr_chk_pkg;

    localparam int HALF_W = 3;

    typedef enum logic [3:0] {
        C_NOP  = 4'd0,
        C_MRS  = 4'd1,
        C_EMRS = 4'd2,
        C_REF  = 4'd3,
        C_SREF = 4'd4,
        C_ACT  = 4'd5,
        C_RD   = 4'd6,
        C_WR   = 4'd7,
        C_BST  = 4'd8,
        C_PRE  = 4'd9
    } cmd_e;

    typedef enum logic [3:0] {
        E_NONE     = 4'd0,
        E_NOT_IDLE = 4'd1,
        E_MRD      = 4'd2,
        E_RFC      = 4'd3,
        E_CLOSED   = 4'd4,
        E_AP_LOCK  = 4'd5,
        E_RCD      = 4'd6,
        E_AP_OTHER = 4'd7,
        E_OPEN     = 4'd8,
        E_RP       = 4'd9,
        E_RC       = 4'd10,
        E_RRD      = 4'd11,
        E_RAS      = 4'd12
    } err_e;

endpackage

// File: rtl/ddr_down_timer.sv
// Module ddr_down_timer
// Minimum-spacing window. A load in cycle t keeps busy_o high in cycles
// t+1 .. t+LIMIT-1, so a command at t+LIMIT or later is legal.
// Assumes LIMIT >= 1.
module ddr_down_timer #(
    parameter int LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic busy_o
);
    localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [W-1:0] RELOAD = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    // Reload on the event, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= RELOAD;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/ddr_cmd_decode.sv
// Module ddr_cmd_decode
// Combinational decode of one bus cycle into a command.
// Assumes the previous-cycle clock enable is supplied by the caller;
// with it low, or chip select high, the cycle is a no-op.
module ddr_cmd_decode
    import ddr_chk_pkg::*;
(
    input  logic cke_prev_i,
    input  logic cke_i,
    input  logic cs_n_i,
    input  logic ras_n_i,
    input  logic cas_n_i,
    input  logic we_n_i,
    input  logic ba0_i,
    output cmd_e cmd_o
);
    // Strobe pattern to command.
    always_comb begin
        cmd_o = C_NOP;
        if (cke_prev_i && !cs_n_i) begin
            case ({ras_n_i, cas_n_i, we_n_i})
                3'b000:  cmd_o = ba0_i ? C_EMRS : C_MRS;
                3'b001:  cmd_o = cke_i ? C_REF : C_SREF;
                3'b011:  cmd_o = C_ACT;
                3'b101:  cmd_o = C_RD;
                3'b100:  cmd_o = C_WR;
                3'b110:  cmd_o = C_BST;
                3'b010:  cmd_o = C_PRE;
                default: cmd_o = C_NOP;
            endcase
        end
    end
endmodule

// File: rtl/ddr_bank_state.sv
// Module ddr_bank_state
// State of one bank: open flag, spacing windows and the auto-precharge
// burst counter. Commands are applied even when they were in violation.
// Assumes at most one of act_i, pre_i, rwap_i is high in a cycle.
module ddr_bank_state
    import ddr_chk_pkg::*;
#(
    parameter int T_RCD = 3,
    parameter int T_RP  = 3,
    parameter int T_RC  = 9,
    parameter int T_RAS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_i,
    input  logic              pre_i,
    input  logic              rwap_i,
    input  logic [HALF_W-1:0] half_bl_i,
    output logic              open_o,
    output logic              rcd_busy_o,
    output logic              rp_busy_o,
    output logic              rc_busy_o,
    output logic              ras_busy_o,
    output logic              ap_busy_o
);
    logic              open_q;
    logic [HALF_W-1:0] ap_q;
    logic              ap_end;
    logic              rp_load;

    assign ap_end  = (ap_q == HALF_W'(1));
    assign rp_load = (pre_i && open_q) || ap_end;

    // Open flag: activate opens, precharge or end of auto-precharge closes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            open_q <= 1'b0;
        else if (act_i)
            open_q <= 1'b1;
        else if (pre_i || ap_end)
            open_q <= 1'b0;
    end

    // Auto-precharge burst: cycles left until the burst ends.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ap_q <= '0;
        else if (act_i || pre_i)
            ap_q <= '0;
        else if (rwap_i && open_q && ap_q == '0)
            ap_q <= half_bl_i;
        else if (ap_q != '0)
            ap_q <= ap_q - 1'b1;
    end

    ddr_down_timer #(.LIMIT(T_RCD)) u_rcd (.clk(clk), .rst_n(rst_n), .load_i(act_i),   .busy_o(rcd_busy_o));
    ddr_down_timer #(.LIMIT(T_RC))  u_rc  (.clk(clk), .rst_n(rst_n), .load_i(act_i),   .busy_o(rc_busy_o));
    ddr_down_timer #(.LIMIT(T_RAS)) u_ras (.clk(clk), .rst_n(rst_n), .load_i(act_i),   .busy_o(ras_busy_o));
    ddr_down_timer #(.LIMIT(T_RP))  u_rp  (.clk(clk), .rst_n(rst_n), .load_i(rp_load), .busy_o(rp_busy_o));

    assign open_o    = open_q;
    assign ap_busy_o = (ap_q != '0);
endmodule

// File: rtl/ddr_rule_check.sv
// Module ddr_rule_check
// Combinational rule evaluation for the current command against the
// bank model. Reports the first failing rule in a fixed priority.
// Assumes the bank vectors show the state before this command applies.
module ddr_rule_check
    import ddr_chk_pkg::*;
#(
    parameter int NB = 4,
    parameter int BW = 2
) (
    input  cmd_e          cmd_i,
    input  logic [BW-1:0] bank_i,
    input  logic          a10_i,
    input  logic [NB-1:0] open_i,
    input  logic [NB-1:0] rcd_i,
    input  logic [NB-1:0] rp_i,
    input  logic [NB-1:0] rc_i,
    input  logic [NB-1:0] ras_i,
    input  logic [NB-1:0] ap_i,
    input  logic          mrd_i,
    input  logic          rfc_i,
    input  logic          rrd_i,
    output err_e          err_o
);
    logic [NB-1:0] sel;
    logic          idle_cmd;
    logic          ras_hit;

    // One-hot bank select, idle-only command group, early-precharge test.
    always_comb begin
        sel      = {{(NB-1){1'b0}}, 1'b1} << bank_i;
        idle_cmd = (cmd_i == C_MRS) || (cmd_i == C_EMRS) ||
                   (cmd_i == C_REF) || (cmd_i == C_SREF);
        ras_hit  = a10_i ? |(open_i & ras_i) : |(sel & open_i & ras_i);
    end

    // Prioritised error selection.
    always_comb begin
        err_o = E_NONE;
        if (cmd_i != C_NOP) begin
            if (idle_cmd && |open_i)
                err_o = E_NOT_IDLE;
            else if (mrd_i)
                err_o = E_MRD;
            else if (rfc_i)
                err_o = E_RFC;
            else begin
                case (cmd_i)
                    C_RD, C_WR: begin
                        if (!(|(sel & open_i)))   err_o = E_CLOSED;
                        else if (|(sel & ap_i))   err_o = E_AP_LOCK;
                        else if (|(sel & rcd_i))  err_o = E_RCD;
                        else if (|(~sel & ap_i))  err_o = E_AP_OTHER;
                    end
                    C_ACT: begin
                        if (|(sel & open_i))      err_o = E_OPEN;
                        else if (|(sel & rp_i))   err_o = E_RP;
                        else if (|(sel & rc_i))   err_o = E_RC;
                        else if (rrd_i)           err_o = E_RRD;
                    end
                    C_PRE: begin
                        if (ras_hit)              err_o = E_RAS;
                    end
                    default: err_o = E_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/dram_cmd_monitor.sv
// Module dram_cmd_monitor
// Top of the DDR command protocol checker: samples the command bus,
// decodes it, checks it against the bank model and reports the command,
// the bank and any violation one cycle later.
// Assumes one command per clock and limits given in clock cycles (>= 1).
module dram_cmd_monitor
    import ddr_chk_pkg::*;
#(
    parameter int BANK_BITS = 2,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RRD     = 2,
    parameter int T_RAS     = 6,
    parameter int T_RC      = 9,
    parameter int T_RFC     = 10,
    parameter int T_MRD     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cke_i,
    input  logic                 cs_n_i,
    input  logic                 ras_n_i,
    input  logic                 cas_n_i,
    input  logic                 we_n_i,
    input  logic [BANK_BITS-1:0] ba_i,
    input  logic                 a10_i,
    input  logic [2:0]           amode_i,
    output logic [3:0]           cmd_o,
    output logic [BANK_BITS-1:0] bank_o,
    output logic                 viol_o,
    output logic [3:0]           err_o
);
    localparam int NB = 1 << BANK_BITS;

    logic              cke_q;
    cmd_e              cmd;
    err_e              err;
    logic [HALF_W-1:0] half_q;
    logic              has_bank;
    logic              is_rw;

    logic [NB-1:0] open_v, rcd_v, rp_v, rc_v, ras_v, ap_v;
    logic [NB-1:0] act_v, pre_v, rwap_v;
    logic          mrd_busy, rfc_busy, rrd_busy;

    cmd_e                 cmd_q;
    logic [BANK_BITS-1:0] bank_q;
    err_e                 err_q;
    logic                 viol_q;

    // Previous-cycle clock enable, used by the decoder.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cke_q <= 1'b1;
        else
            cke_q <= cke_i;
    end

    ddr_cmd_decode u_dec (
        .cke_prev_i (cke_q),
        .cke_i      (cke_i),
        .cs_n_i     (cs_n_i),
        .ras_n_i    (ras_n_i),
        .cas_n_i    (cas_n_i),
        .we_n_i     (we_n_i),
        .ba0_i      (ba_i[0]),
        .cmd_o      (cmd)
    );

    // Half burst length from the last mode set with a valid code.
    always_ff @(posedge clk) begin
        if (!rst_n)
            half_q <= HALF_W'(4);
        else if (cmd == C_MRS) begin
            case (amode_i)
                3'b001:  half_q <= HALF_W'(1);
                3'b010:  half_q <= HALF_W'(2);
                3'b011:  half_q <= HALF_W'(4);
                default: half_q <= half_q;
            endcase
        end
    end

    assign is_rw    = (cmd == C_RD) || (cmd == C_WR);
    assign has_bank = is_rw || (cmd == C_ACT) || (cmd == C_PRE);

    generate
        for (genvar b = 0; b < NB; b++) begin : g_bank
            assign act_v[b]  = (cmd == C_ACT) && (ba_i == BANK_BITS'(b));
            assign pre_v[b]  = (cmd == C_PRE) && (a10_i || ba_i == BANK_BITS'(b));
            assign rwap_v[b] = is_rw && a10_i && (ba_i == BANK_BITS'(b));

            ddr_bank_state #(
                .T_RCD (T_RCD),
                .T_RP  (T_RP),
                .T_RC  (T_RC),
                .T_RAS (T_RAS)
            ) u_bank (
                .clk        (clk),
                .rst_n      (rst_n),
                .act_i      (act_v[b]),
                .pre_i      (pre_v[b]),
                .rwap_i     (rwap_v[b]),
                .half_bl_i  (half_q),
                .open_o     (open_v[b]),
                .rcd_busy_o (rcd_v[b]),
                .rp_busy_o  (rp_v[b]),
                .rc_busy_o  (rc_v[b]),
                .ras_busy_o (ras_v[b]),
                .ap_busy_o  (ap_v[b])
            );
        end
    endgenerate

    ddr_down_timer #(.LIMIT(T_MRD)) u_mrd (
        .clk(clk), .rst_n(rst_n), .load_i((cmd == C_MRS) || (cmd == C_EMRS)), .busy_o(mrd_busy));
    ddr_down_timer #(.LIMIT(T_RFC)) u_rfc (
        .clk(clk), .rst_n(rst_n), .load_i(cmd == C_REF), .busy_o(rfc_busy));
    ddr_down_timer #(.LIMIT(T_RRD)) u_rrd (
        .clk(clk), .rst_n(rst_n), .load_i(cmd == C_ACT), .busy_o(rrd_busy));

    ddr_rule_check #(.NB(NB), .BW(BANK_BITS)) u_rules (
        .cmd_i  (cmd),
        .bank_i (ba_i),
        .a10_i  (a10_i),
        .open_i (open_v),
        .rcd_i  (rcd_v),
        .rp_i   (rp_v),
        .rc_i   (rc_v),
        .ras_i  (ras_v),
        .ap_i   (ap_v),
        .mrd_i  (mrd_busy),
        .rfc_i  (rfc_busy),
        .rrd_i  (rrd_busy),
        .err_o  (err)
    );

    // Output register: decoded command, bank and violation of this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= C_NOP;
            bank_q <= '0;
            err_q  <= E_NONE;
            viol_q <= 1'b0;
        end else begin
            cmd_q  <= cmd;
            bank_q <= has_bank ? ba_i : '0;
            err_q  <= err;
            viol_q <= (err != E_NONE);
        end
    end

    assign cmd_o  = cmd_q;
    assign bank_o = bank_q;
    assign err_o  = err_q;
    assign viol_o = viol_q;
endmodule

// File: rtl/dram_cmd_monitor_props.sv
// Module dram_cmd_monitor_props
// Assertion checker bound to dram_cmd_monitor. It relates the reported
// error code to the reported command and to the previous command.
module dram_cmd_monitor_props (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] cmd_o,
    input logic       viol_o,
    input logic [3:0] err_o
);
    // R2: a reported no-op never carries a violation.
    p_nop_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 4'd0) |-> !viol_o);

    // R3: the not-idle code only follows mode set, refresh or self-refresh.
    p_idle_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o == 4'd1) |-> (cmd_o inside {4'd1, 4'd2, 4'd3, 4'd4}));

    // R4: a bank command right after a mode set is always flagged.
    p_mrd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(cmd_o) == 4'd1 || $past(cmd_o) == 4'd2) &&
         (cmd_o inside {4'd5, 4'd6, 4'd7, 4'd8, 4'd9})) |-> viol_o);

    // R8: activate spacing codes only on activates.
    p_act_codes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o inside {4'd8, 4'd9, 4'd10, 4'd11}) |-> (cmd_o == 4'd5));

    // R9: the early-precharge code only on precharges.
    p_ras_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o == 4'd12) |-> (cmd_o == 4'd9));

    // R11: auto-precharge lockout codes only on reads and writes.
    p_ap_codes_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o inside {4'd4, 4'd5, 4'd6, 4'd7}) |-> (cmd_o inside {4'd6, 4'd7}));
endmodule

bind dram_cmd_monitor dram_cmd_monitor_props u_props (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd_o  (cmd_o),
    .viol_o (viol_o),
    .err_o  (err_o)
);

// File: tb/dram_cmd_monitor_bench.sv
// Scoreboard bench: driver tasks push one expected item per cycle,
// a monitor pops and compares 1 ns after each rising edge.
module dram_cmd_monitor_bench;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n, cke, cs_n, ras_n, cas_n, we_n, a10;
    logic [1:0] ba;
    logic [2:0] amode;
    logic [3:0] cmd_o, err_o;
    logic [1:0] bank_o;
    logic       viol_o;

    dram_cmd_monitor u_dram_cmd_monitor (
        .clk(clk), .rst_n(rst_n), .cke_i(cke), .cs_n_i(cs_n), .ras_n_i(ras_n),
        .cas_n_i(cas_n), .we_n_i(we_n), .ba_i(ba), .a10_i(a10), .amode_i(amode),
        .cmd_o(cmd_o), .bank_o(bank_o), .viol_o(viol_o), .err_o(err_o));

    localparam int K_NOP = 0, K_MRS = 1, K_EMRS = 2, K_REF = 3, K_SREF = 4;
    localparam int K_ACT = 5, K_RD = 6, K_WR = 7, K_BST = 8, K_PRE = 9;
    localparam int X_NOT_IDLE = 1, X_MRD = 2, X_RFC = 3, X_CLOSED = 4, X_AP_LOCK = 5;
    localparam int X_RCD = 6, X_AP_OTHER = 7, X_OPEN = 8, X_RP = 9, X_RC = 10;
    localparam int X_RRD = 11, X_RAS = 12;

    typedef struct {
        int    cmd;
        int    bank;
        int    err;
        string req;
    } exp_t;

    exp_t sb[$];
    exp_t mon_it;
    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    task automatic drive(input logic c_cs, input logic c_ras, input logic c_cas,
                         input logic c_we, input int c_ba, input logic c_a10,
                         input logic [2:0] c_am, input logic c_cke,
                         input int e_cmd, input int e_bank, input int e_err,
                         input string req);
        exp_t it;
        @(negedge clk);
        cs_n = c_cs; ras_n = c_ras; cas_n = c_cas; we_n = c_we;
        ba = 2'(c_ba); a10 = c_a10; amode = c_am; cke = c_cke;
        it.cmd = e_cmd; it.bank = e_bank; it.err = e_err; it.req = req;
        sb.push_back(it);
    endtask

    task automatic nop(input int n);
        for (int i = 0; i < n; i++)
            drive(1'b0, 1'b1, 1'b1, 1'b1, 0, 1'b0, 3'b000, 1'b1, K_NOP, 0, 0, "R1");
    endtask
    task automatic act(input int b, input int e, input string r);
        drive(1'b0, 1'b0, 1'b1, 1'b1, b, 1'b0, 3'b000, 1'b1, K_ACT, b, e, r);
    endtask
    task automatic rd(input int b, input logic ap, input int e, input string r);
        drive(1'b0, 1'b1, 1'b0, 1'b1, b, ap, 3'b000, 1'b1, K_RD, b, e, r);
    endtask
    task automatic wr(input int b, input logic ap, input int e, input string r);
        drive(1'b0, 1'b1, 1'b0, 1'b0, b, ap, 3'b000, 1'b1, K_WR, b, e, r);
    endtask
    task automatic pre(input int b, input logic all, input int e, input string r);
        drive(1'b0, 1'b0, 1'b1, 1'b0, b, all, 3'b000, 1'b1, K_PRE, b, e, r);
    endtask
    task automatic mrs(input int b, input logic [2:0] am, input int e, input string r);
        drive(1'b0, 1'b0, 1'b0, 1'b0, b, 1'b0, am, 1'b1, (b % 2 == 1) ? K_EMRS : K_MRS, 0, e, r);
    endtask
    task automatic refr(input int e, input string r);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 0, 1'b0, 3'b000, 1'b1, K_REF, 0, e, r);
    endtask
    task automatic bst(input int e, input string r);
        drive(1'b0, 1'b1, 1'b1, 1'b0, 0, 1'b0, 3'b000, 1'b1, K_BST, 0, e, r);
    endtask

    // Monitor: compare one expected item per cycle after the output register.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            mon_it = sb.pop_front();
            n_run++;
            if (int'(cmd_o) != mon_it.cmd || int'(bank_o) != mon_it.bank ||
                int'(err_o) != mon_it.err || viol_o != (mon_it.err != 0)) begin
                n_fail++;
                $display("FAIL %s: got cmd=%0d bank=%0d viol=%0b err=%0d, expected cmd=%0d bank=%0d viol=%0b err=%0d",
                         mon_it.req, cmd_o, bank_o, viol_o, err_o,
                         mon_it.cmd, mon_it.bank, (mon_it.err != 0), mon_it.err);
            end
        end
    end

    initial begin
        rst_n = 1'b0; cke = 1'b1; cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1;
        we_n = 1'b1; ba = 2'd0; a10 = 1'b0; amode = 3'd0;
        repeat (3) @(posedge clk);
        #1;
        n_run++;
        if (cmd_o != 4'd0 || bank_o != 2'd0 || viol_o != 1'b0 || err_o != 4'd0) begin
            n_fail++;
            $display("FAIL R13 reset: got cmd=%0d bank=%0d viol=%0b err=%0d, expected all 0",
                     cmd_o, bank_o, viol_o, err_o);
        end
        @(negedge clk);
        rst_n = 1'b1;

        mrs(0, 3'b010, 0, "R12");           // burst length 4
        bst(X_MRD, "R4");                    // 1 cycle after mode set
        nop(1);
        act(0, 0, "R1");                     // t=0
        rd(0, 1'b0, X_RCD, "R7");            // t=1
        nop(1);
        rd(0, 1'b0, 0, "R7");                // t=3
        act(1, 0, "R8");                     // t=4
        act(2, X_RRD, "R8");                 // t=5
        pre(0, 1'b0, 0, "R9");               // t=6, exactly T_RAS
        act(0, X_RP, "R14");                 // t=7, RP wins over RC
        nop(2);
        act(0, X_OPEN, "R13");               // t=10, bank reopened at t=7
        pre(1, 1'b0, 0, "R9");               // t=11
        pre(2, 1'b0, 0, "R9");               // t=12
        pre(0, 1'b0, X_RAS, "R13");          // t=13, timers reloaded at t=10
        nop(2);
        act(0, X_RC, "R8");                  // t=16
        rd(1, 1'b0, X_CLOSED, "R6");         // t=17
        refr(X_NOT_IDLE, "R3");              // t=18
        pre(2, 1'b1, X_RFC, "R5");           // t=19, all banks
        nop(8);
        act(3, 0, "R5");                     // t=28, exactly T_RFC
        nop(1);
        act(0, 0, "R10");                    // t=30, all-bank precharge closed bank 0
        nop(2);
        wr(0, 1'b1, 0, "R11");               // t=33, auto-precharge, half burst 2
        rd(0, 1'b0, X_AP_LOCK, "R11");       // t=34
        rd(3, 1'b0, X_AP_OTHER, "R11");      // t=35
        rd(0, 1'b0, X_CLOSED, "R11");        // t=36
        act(0, X_RP, "R11");                 // t=37
        rd(3, 1'b0, 0, "R11");               // t=38
        nop(4);
        pre(1, 1'b1, 0, "R10");              // t=43, all banks
        nop(1);
        mrs(1, 3'b001, 0, "R12");            // t=45, extended set, no change
        nop(2);
        act(1, 0, "R12");                    // t=48
        nop(2);
        wr(1, 1'b1, 0, "R12");               // t=51
        nop(1);
        rd(1, 1'b0, X_AP_LOCK, "R12");       // t=53, still burst length 4
        rd(1, 1'b0, X_CLOSED, "R12");        // t=54
        mrs(0, 3'b011, 0, "R12");            // t=55, burst length 8
        nop(1);
        act(2, 0, "R12");                    // t=57
        nop(2);
        rd(2, 1'b1, 0, "R12");               // t=60, half burst 4
        nop(3);
        rd(2, 1'b0, X_AP_LOCK, "R12");       // t=64
        rd(2, 1'b0, X_CLOSED, "R12");        // t=65
        drive(1'b0, 1'b0, 1'b0, 1'b1, 0, 1'b0, 3'b000, 1'b0, K_SREF, 0, 0, "R1");  // t=66
        drive(1'b0, 1'b1, 1'b1, 1'b1, 0, 1'b0, 3'b000, 1'b0, K_NOP, 0, 0, "R2");   // t=67
        drive(1'b0, 1'b0, 1'b1, 1'b1, 3, 1'b0, 3'b000, 1'b1, K_NOP, 0, 0, "R2");   // t=68
        act(3, 0, "R2");                     // t=69, previous activate was ignored
        mrs(0, 3'b001, X_NOT_IDLE, "R3");    // t=70
        drive(1'b1, 1'b0, 1'b1, 1'b1, 3, 1'b0, 3'b000, 1'b1, K_NOP, 0, 0, "R2");   // t=71
        act(3, X_OPEN, "R6");                // t=72
        nop(5);
        pre(3, 1'b1, 0, "R10");              // t=78
        refr(0, "R3");                       // t=79
        bst(X_RFC, "R5");                    // t=80
        nop(1);

        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got no end, expected end of sequence");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule